// File: doc/BRIEF.md
# Base Address Register Decoder

This block holds the base address registers of a bus target and decides, for each presented bus address, which of them the access falls into. The host loads each register through a configuration write port. A register stores only its top bits, and the number of those bits fixes the size of its window. The bits below that point are tied to zero, so firmware can find the size of a region by writing all ones and reading the register back. The type bits at the bottom of each register are fixed.

Decoding is combinational. For an address and access type, each enabled register compares its stored top bits with the same bits of the address. The block returns one hit line per register, a combined hit flag, and the address bits below the window boundary as the offset into the matched region. By default there are two registers: a 32 MB memory window and a 256-byte I/O window for control registers. Per-register window sizes and types are parameter vectors, so more registers can be added.

Top module: `bar_decode_unit`

## Requirements
- R1: After reset, a memory register reads 0x00000000 and an I/O register reads 0x00000001. A read select beyond the last register returns 0x00000000.
- R2: Writing 0xFFFFFFFF with all byte enables reads back as the size mask. This is 0xFE000000 for a 32 MB memory window, 0xFFF00000 for a 1 MB memory window and 0xFFFFFF01 for a 256-byte I/O window.
- R3: The type bits cannot be written. A memory register reads bits 3:0 as 0000, and an I/O register reads bits 1:0 as 01. No other bit below the window boundary ever reads as 1.
- R4: cfg_wr_be[k] enables data bits 8k+7..8k. A write updates only the stored bits inside enabled bytes. All other bits keep their values.
- R5: A memory access (bus_is_io=0) hits a memory register when mem_space_en=1 and the address bits at and above the window boundary equal the register's stored bits.
- R6: An I/O access (bus_is_io=1) hits an I/O register when io_space_en=1 and the address bits at and above the window boundary equal the register's stored bits.
- R7: No register hits while its space enable is 0, or when the access type differs from the register type.
- R8: hit_offset equals the address bits below the window boundary of the winning register. It is 0 when nothing hits.
- R9: At most one hit line is high. When several registers match, the lowest-numbered one wins.
- R10: Decoding follows the most recent write. A register keeps its value until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | SEL_W | Register index for the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables for the write |
| cfg_rd_sel | input | SEL_W | Register index for readback |
| cfg_rd_data | output | 32 | Readback value, combinational |
| mem_space_en | input | 1 | Enables decoding of memory registers |
| io_space_en | input | 1 | Enables decoding of I/O registers |
| bus_addr | input | 32 | Address under decode |
| bus_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| hit | output | NUM_BARS | One-hot hit per register |
| hit_any | output | 1 | Some register hit |
| hit_offset | output | 32 | Offset inside the matched window |

## Verification
The assertions check four properties on every cycle: the hit vector is one-hot, no hit appears without the matching space enable, the offset is zero with no hit, and readback holds while no write occurs. They also check that an all-ones write to register 0 reads back as its size mask. Only the bench scenarios can show the remaining behaviour: the exact hit and offset values for addresses just inside and just outside each window, the priority between overlapping windows, partial writes under byte enables, and decoding that follows a base address after it has been moved.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
   localparam int BAR_W = 32;
   localparam int BE_W  = BAR_W / 8;

   typedef enum logic {
      BAR_KIND_MEM = 1'b0,
      BAR_KIND_IO  = 1'b1
   } bar_kind_e;

   // Bits below the window boundary
   function automatic logic [BAR_W-1:0] window_low_mask(input int size_log2);
      return (BAR_W'(1) << size_log2) - BAR_W'(1);
   endfunction

   // Spread byte enables over data bits
   function automatic logic [BAR_W-1:0] expand_be(input logic [BE_W-1:0] be);
      logic [BAR_W-1:0] m;
      for (int k = 0; k < BE_W; k++) m[k*8 +: 8] = {8{be[k]}};
      return m;
   endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot
   import bar_dec_pkg::*;
#(
   parameter int SIZE_LOG2 = 25,
   parameter bit IS_IO     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [BAR_W-1:0] wr_data,
   input  logic [BE_W-1:0]  wr_be,
   output logic [BAR_W-1:0] bar_val
);
   localparam int UP_W = BAR_W - SIZE_LOG2;
   localparam int MIN_LOG2 = IS_IO ? 2 : 4;

   if (SIZE_LOG2 < MIN_LOG2 || SIZE_LOG2 > BAR_W - 1) begin : g_bad_size
      $error("bar_slot: SIZE_LOG2 out of range for this register type");
   end

   logic [UP_W-1:0] upper_q;
   logic [UP_W-1:0] upper_wmask;

   assign upper_wmask = expand_be(wr_be) >> SIZE_LOG2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
      end else if (wr_stb) begin
         upper_q <= (upper_q & ~upper_wmask) | ((wr_data >> SIZE_LOG2) & upper_wmask);
      end
   end

   logic [BAR_W-1:0] type_bits;
   if (IS_IO) begin : g_io_type
      assign type_bits = BAR_W'(1);
   end else begin : g_mem_type
      assign type_bits = '0;
   end

   assign bar_val = {upper_q, {SIZE_LOG2{1'b0}}} | type_bits;
endmodule

// File: rtl/bar_match.sv
module bar_match
   import bar_dec_pkg::*;
#(
   parameter int SIZE_LOG2 = 25,
   parameter bit IS_IO     = 1'b0
) (
   input  logic [BAR_W-1:0] bar_val,
   input  logic [BAR_W-1:0] bus_addr,
   input  logic             bus_is_io,
   input  logic             space_en,
   output logic             match,
   output logic [BAR_W-1:0] offset
);
   localparam logic [BAR_W-1:0] LOW_MASK = window_low_mask(SIZE_LOG2);
   localparam bar_kind_e KIND = IS_IO ? BAR_KIND_IO : BAR_KIND_MEM;

   logic kind_ok;
   logic upper_eq;

   assign kind_ok  = (bar_kind_e'(bus_is_io) == KIND);
   assign upper_eq = (((bus_addr ^ bar_val) & ~LOW_MASK) == '0);
   assign match    = space_en && kind_ok && upper_eq;
   assign offset   = bus_addr & LOW_MASK;
endmodule

// File: rtl/bar_prio.sv
module bar_prio
   import bar_dec_pkg::*;
#(
   parameter int NUM = 2
) (
   input  logic [NUM-1:0]       match,
   input  logic [NUM*BAR_W-1:0] offsets,
   output logic [NUM-1:0]       hit,
   output logic [BAR_W-1:0]     offset
);
   always_comb begin
      logic taken;
      taken  = 1'b0;
      hit    = '0;
      offset = '0;
      for (int i = 0; i < NUM; i++) begin
         if (match[i] && !taken) begin
            taken  = 1'b1;
            hit[i] = 1'b1;
            offset = offsets[i*BAR_W +: BAR_W];
         end
      end
   end
endmodule

// File: rtl/bar_decode_unit.sv
module bar_decode_unit
   import bar_dec_pkg::*;
#(
   parameter int                    NUM_BARS      = 2,
   parameter logic [NUM_BARS*8-1:0] SIZE_LOG2_VEC = {8'd8, 8'd25},
   parameter logic [NUM_BARS-1:0]   IS_IO_VEC     = 2'b10,
   localparam int                   SEL_W         = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [SEL_W-1:0]    cfg_wr_sel,
   input  logic [BAR_W-1:0]    cfg_wr_data,
   input  logic [BE_W-1:0]     cfg_wr_be,
   input  logic [SEL_W-1:0]    cfg_rd_sel,
   output logic [BAR_W-1:0]    cfg_rd_data,
   input  logic                mem_space_en,
   input  logic                io_space_en,
   input  logic [BAR_W-1:0]    bus_addr,
   input  logic                bus_is_io,
   output logic [NUM_BARS-1:0] hit,
   output logic                hit_any,
   output logic [BAR_W-1:0]    hit_offset
);
   if (NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_count
      $error("bar_decode_unit: NUM_BARS must be 1 to 6");
   end

   logic [BAR_W-1:0]          bar_vals [NUM_BARS];
   logic [NUM_BARS-1:0]       match;
   logic [NUM_BARS*BAR_W-1:0] offsets;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam int SZ = int'(SIZE_LOG2_VEC[i*8 +: 8]);
      localparam bit IO = IS_IO_VEC[i];

      logic wr_stb;
      logic space_en;

      assign wr_stb   = cfg_wr_en && (cfg_wr_sel == SEL_W'(i));
      assign space_en = IO ? io_space_en : mem_space_en;

      bar_slot #(.SIZE_LOG2(SZ), .IS_IO(IO)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_stb  (wr_stb),
         .wr_data (cfg_wr_data),
         .wr_be   (cfg_wr_be),
         .bar_val (bar_vals[i])
      );

      bar_match #(.SIZE_LOG2(SZ), .IS_IO(IO)) u_match (
         .bar_val   (bar_vals[i]),
         .bus_addr  (bus_addr),
         .bus_is_io (bus_is_io),
         .space_en  (space_en),
         .match     (match[i]),
         .offset    (offsets[i*BAR_W +: BAR_W])
      );
   end

   bar_prio #(.NUM(NUM_BARS)) u_prio (
      .match   (match),
      .offsets (offsets),
      .hit     (hit),
      .offset  (hit_offset)
   );

   assign hit_any = |match;

   always_comb begin
      cfg_rd_data = '0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (cfg_rd_sel == SEL_W'(i)) cfg_rd_data = bar_vals[i];
      end
   end
endmodule

// File: rtl/bar_dec_chk.sv
module bar_dec_chk
   import bar_dec_pkg::*;
#(
   parameter int                    NUM_BARS      = 2,
   parameter logic [NUM_BARS*8-1:0] SIZE_LOG2_VEC = {8'd8, 8'd25},
   parameter logic [NUM_BARS-1:0]   IS_IO_VEC     = 2'b10,
   localparam int                   SEL_W         = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_wr_en,
   input logic [SEL_W-1:0]    cfg_wr_sel,
   input logic [BAR_W-1:0]    cfg_wr_data,
   input logic [BE_W-1:0]     cfg_wr_be,
   input logic [SEL_W-1:0]    cfg_rd_sel,
   input logic [BAR_W-1:0]    cfg_rd_data,
   input logic                mem_space_en,
   input logic                io_space_en,
   input logic [BAR_W-1:0]    bus_addr,
   input logic                bus_is_io,
   input logic [NUM_BARS-1:0] hit,
   input logic                hit_any,
   input logic [BAR_W-1:0]    hit_offset
);
   localparam logic [BAR_W-1:0] SIZE0_EXP =
      ~window_low_mask(int'(SIZE_LOG2_VEC[7:0])) | BAR_W'(IS_IO_VEC[0]);

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R9

   AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> (bus_is_io ? io_space_en : mem_space_en)); // R7

   AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (hit_offset == '0)); // R8

   AST_SIZE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_sel == '0 && cfg_wr_be == '1 && cfg_wr_data == '1)
      |=> (cfg_rd_sel != '0 || cfg_rd_data == SIZE0_EXP)); // R2

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_en |=> (!$stable(cfg_rd_sel) || $stable(cfg_rd_data))); // R10
endmodule

bind bar_decode_unit bar_dec_chk #(
   .NUM_BARS      (NUM_BARS),
   .SIZE_LOG2_VEC (SIZE_LOG2_VEC),
   .IS_IO_VEC     (IS_IO_VEC)
) u_chk (.*);

// File: tb/sim_bar_decode_unit.sv
module sim_bar_decode_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 3;
   localparam int SW = 2;

   typedef struct packed {
      logic [31:0] addr;
      logic        io;
      logic [2:0]  hit;
      logic [31:0] off;
   } vec_t;

   // bar0 = 0x42000000 (32 MB mem), bar1 = 0x0000C100 (256 B io), bar2 = 0x42100000 (1 MB mem)
   localparam vec_t VECS [9] = '{
      '{32'h4200_0010, 1'b0, 3'b001, 32'h0000_0010},
      '{32'h43FF_FFFC, 1'b0, 3'b001, 32'h01FF_FFFC},
      '{32'h4210_0004, 1'b0, 3'b001, 32'h0010_0004},
      '{32'h4400_0000, 1'b0, 3'b000, 32'h0},
      '{32'h41FF_FFFF, 1'b0, 3'b000, 32'h0},
      '{32'h0000_C1A4, 1'b1, 3'b010, 32'h0000_00A4},
      '{32'h0000_C200, 1'b1, 3'b000, 32'h0},
      '{32'h0000_C1A4, 1'b0, 3'b000, 32'h0},
      '{32'h4200_0010, 1'b1, 3'b000, 32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [SW-1:0] cfg_wr_sel = '0;
   logic [31:0]   cfg_wr_data = '0;
   logic [3:0]    cfg_wr_be = '0;
   logic [SW-1:0] cfg_rd_sel = '0;
   logic [31:0]   cfg_rd_data;
   logic          mem_space_en = 1'b0;
   logic          io_space_en = 1'b0;
   logic [31:0]   bus_addr = '0;
   logic          bus_is_io = 1'b0;
   logic [NB-1:0] hit;
   logic          hit_any;
   logic [31:0]   hit_offset;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bar_decode_unit #(
      .NUM_BARS      (NB),
      .SIZE_LOG2_VEC ({8'd20, 8'd8, 8'd25}),
      .IS_IO_VEC     (3'b010)
   ) u0 (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [31:0] data, input logic [3:0] be);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = SW'(sel); cfg_wr_data = data; cfg_wr_be = be;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input int sel, input logic [31:0] exp);
      cfg_rd_sel = SW'(sel);
      #1;
      chk(tag, cfg_rd_data, exp);
   endtask

   task automatic dec_chk(input string tag, input logic [31:0] a, input logic io,
                          input logic [2:0] eh, input logic [31:0] eo);
      bus_addr = a; bus_is_io = io;
      #1;
      chk({tag, " hit"}, 32'(hit), 32'(eh));
      chk({tag, " off"}, hit_offset, eo);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd_chk("R1 bar0 reset", 0, 32'h0000_0000);
      rd_chk("R1 bar1 reset", 1, 32'h0000_0001);
      rd_chk("R1 bar2 reset", 2, 32'h0000_0000);
      rd_chk("R1 sel beyond last", 3, 32'h0000_0000);
      // R7 disabled spaces never hit, even on the reset base
      dec_chk("R7 reset disabled", 32'h0000_0000, 1'b0, 3'b000, 32'h0);

      // R2 / R3 sizing
      wr(0, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R2 size bar0", 0, 32'hFE00_0000);
      wr(1, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R2 R3 size bar1", 1, 32'hFFFF_FF01);
      wr(2, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R2 size bar2", 2, 32'hFFF0_0000);
      wr(1, 32'h0000_0000, 4'hF);
      rd_chk("R3 io type bit kept", 1, 32'h0000_0001);

      // program bases
      wr(0, 32'h4200_0000, 4'hF);
      wr(1, 32'h0000_C100, 4'hF);
      wr(2, 32'h4210_0000, 4'hF);
      rd_chk("R10 bar1 base", 1, 32'h0000_C101);

      mem_space_en = 1'b1;
      io_space_en  = 1'b1;
      // R5 R6 R7 R8 R9 table
      foreach (VECS[i]) begin
         dec_chk($sformatf("R5 R6 R8 R9 vec%0d", i), VECS[i].addr, VECS[i].io,
                 VECS[i].hit, VECS[i].off);
      end

      // R7 memory space disabled, I/O still on
      mem_space_en = 1'b0;
      dec_chk("R7 mem off", 32'h4200_0010, 1'b0, 3'b000, 32'h0);
      dec_chk("R7 io unaffected", 32'h0000_C1FF, 1'b1, 3'b010, 32'h0000_00FF);
      io_space_en = 1'b0;
      dec_chk("R7 io off", 32'h0000_C1FF, 1'b1, 3'b000, 32'h0);
      mem_space_en = 1'b1;
      io_space_en  = 1'b1;

      // R10 move bar0 away: bar2 now wins its own window
      wr(0, 32'h8000_0000, 4'hF);
      dec_chk("R10 R9 bar2 alone", 32'h4210_0004, 1'b0, 3'b100, 32'h0000_0004);
      dec_chk("R10 bar0 moved", 32'h8000_0020, 1'b0, 3'b001, 32'h0000_0020);
      dec_chk("R10 old bar0 gone", 32'h4200_0010, 1'b0, 3'b000, 32'h0);

      // R4 byte enables
      wr(0, 32'hFFFF_FFFF, 4'h7);
      rd_chk("R4 bar0 low bytes only", 0, 32'h8000_0000);
      wr(2, 32'h5555_5555, 4'h4);
      rd_chk("R4 bar2 byte2", 2, 32'h4250_0000);
      dec_chk("R4 bar2 decode", 32'h4250_0100, 1'b0, 3'b100, 32'h0000_0100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule